// File: doc/BRIEF.md
# Timing reference selection controller

This block decides which of several input timing references a clock timing generator follows. It holds two selector channels, a leader and a follower. Each channel picks its reference in one of three ways. In automatic mode it runs a priority election over the qualified references. In manual mode a configuration code names a reference or forces holdover or freerun. The leader also has a pin mode: the level of an external switch pin picks one of two preset codes. The follower has no pin mode. In manual mode it can instead take over whatever the leader is selecting.

Each channel reports a selected reference index and a two-bit state code: locked, holdover or freerun. It also reports the index chosen by its automatic election. The election runs in every mode, so this index can be read at any time. When no reference can be elected, the election falls back to holdover if holdover history is valid, and to freerun otherwise. The election can be revertive, where a better reference takes over at once. It can also be non-revertive, where the current reference is kept until it drops out.

Top module: `refSelector`

## Requirements
- R1: While reset is asserted, both channels report selected index 0, state code 2'b10 (freerun), and election index 0.
- R2: A reference is eligible when its qualified bit is 1 and its 4-bit priority field (bits 4*i+3..4*i of `refPrio`) is nonzero. The election picks the eligible reference with the smallest priority value, and among equal values the lowest index. Priority 0 excludes a reference even when it is qualified.
- R3: With the revertive bit set, a locked election moves to the best eligible reference once that reference's priority value is strictly smaller than the current one's. The move shows on the outputs one clock edge after the input change.
- R4: With the revertive bit clear, a locked election keeps its reference as long as it stays eligible. It re-elects only when that reference loses its qualified bit or its priority becomes 0.
- R5: State codes are 2'b00 locked, 2'b01 holdover and 2'b10 freerun; 2'b11 never appears. With no eligible reference, automatic mode reports holdover when `holdoverOk` is 1 and freerun when it is 0, and the election index keeps its last value.
- R6: From holdover or freerun, the election locks to the best eligible reference one clock edge after any reference becomes eligible.
- R7: The election index output follows the automatic election in every mode, including while the selected output is under manual or pin control.
- R8: Mode code 2'b01 is manual. Manual codes 0..7 lock to that reference index, code 8 forces holdover and code 9 forces freerun. Codes 11..15 give freerun, and so does code 10 on the leader. For holdover and freerun the selected index keeps its previous value. The result appears one edge after the input change.
- R9: Mode code 2'b10 on the leader is pin mode. The pin goes through a two-flop synchroniser. A low level uses preset bits 3..0 and a high level uses bits 7..4, each decoded as in R8. A pin change reaches the outputs on the third clock edge. Mode 2'b11 on the leader, and modes 2'b10 and 2'b11 on the follower, act as automatic mode.
- R10: Manual code 10 on the follower makes its selected index and state equal the leader's on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| refQualified | input | 8 | Qualified flag for each reference |
| refPrio | input | 32 | 4-bit priority for each reference, reference i in bits 4*i+3..4*i |
| holdoverOk | input | 1 | Holdover history is valid |
| pinSwitch | input | 1 | Asynchronous switch pin for leader pin mode |
| priMode | input | 2 | Leader mode: 00 auto, 01 manual, 10 pin |
| priRevertive | input | 1 | Leader election is revertive |
| priManual | input | 4 | Leader manual code |
| priPreset | input | 8 | Leader pin presets: low level in 3..0, high level in 7..4 |
| secMode | input | 2 | Follower mode: 01 manual, otherwise auto |
| secRevertive | input | 1 | Follower election is revertive |
| secManual | input | 4 | Follower manual code, 10 follows the leader |
| priSelIdx | output | 3 | Leader selected reference index |
| priSelState | output | 2 | Leader state code |
| priAutoIdx | output | 3 | Leader election index |
| secSelIdx | output | 3 | Follower selected reference index |
| secSelState | output | 2 | Follower state code |
| secAutoIdx | output | 3 | Follower election index |

## Verification
The properties assume that the configuration inputs (mode, revertive bit, manual and preset codes) and the qualification and priority inputs are synchronous to the clock. Only the switch pin may change asynchronously. The bench drives every input, the pin included, on the falling edge, so each one is stable at the rising edge that samples it. The election properties also assume that the mode was automatic on the previous edge. The bench changes the mode only at the boundaries between phases, and the pin phase holds its level for at least three edges before any check that depends on it.

// File: rtl/refSelPkg.sv
package refSelPkg;

  typedef enum logic [1:0] {
    ST_LOCK = 2'b00,
    ST_HOLD = 2'b01,
    ST_FREE = 2'b10
  } selState_e;

  typedef enum logic [1:0] {
    SRC_AUTO = 2'b00,
    SRC_CODE = 2'b01,
    SRC_PEER = 2'b10
  } outSrc_e;

  localparam logic [1:0] MODE_AUTO   = 2'b00;
  localparam logic [1:0] MODE_MANUAL = 2'b01;
  localparam logic [1:0] MODE_PIN    = 2'b10;

  // control -> datapath strobes
  typedef struct packed {
    logic      loadBest;
    selState_e nextState;
    outSrc_e   outSrc;
  } ctrlStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic anyEligible;
    logic curEligible;
    logic bestBetter;
  } pathFlag_t;

endpackage

// File: rtl/refPinSync.sv
module refPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/refSelPath.sv
module refSelPath
  import refSelPkg::*;
#(
  parameter int N_REFS = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [N_REFS-1:0]        refQualified,
  input  logic [N_REFS*PRIO_W-1:0] refPrio,
  input  ctrlStrobe_t              strobe,
  input  logic [CODE_W-1:0]        selCode,
  input  logic [IDX_W-1:0]         peerIdx,
  input  selState_e                peerState,
  output pathFlag_t                flags,
  output logic [IDX_W-1:0]         selIdx,
  output selState_e                selState,
  output logic [IDX_W-1:0]         autoIdx,
  output logic [IDX_W-1:0]         nextIdx,
  output selState_e                nextState
);
  localparam logic [CODE_W-1:0] HOLD_CODE = CODE_W'(N_REFS);

  logic [PRIO_W-1:0] prioArr [N_REFS];
  logic [N_REFS-1:0] eligible;
  logic              bestFound;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  electedIdx;
  logic [IDX_W-1:0]  autoNext;

  for (genvar g = 0; g < N_REFS; g++) begin : gRef
    assign prioArr[g]  = refPrio[g*PRIO_W +: PRIO_W];
    assign eligible[g] = refQualified[g] && (prioArr[g] != '0);
  end

  // smallest nonzero priority wins, strict compare keeps lowest index on ties
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestPrio  = '1;
    for (int i = 0; i < N_REFS; i++) begin
      if (eligible[i] && (!bestFound || prioArr[i] < bestPrio)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(i);
        bestPrio  = prioArr[i];
      end
    end
  end

  assign flags.anyEligible = bestFound;
  assign flags.curEligible = eligible[electedIdx];
  assign flags.bestBetter  = bestPrio < prioArr[electedIdx];

  assign autoNext = strobe.loadBest ? bestIdx : electedIdx;

  always_comb begin
    nextIdx   = selIdx;
    nextState = ST_FREE;
    case (strobe.outSrc)
      SRC_AUTO: begin
        nextIdx   = autoNext;
        nextState = strobe.nextState;
      end
      SRC_CODE: begin
        if (selCode < HOLD_CODE) begin
          nextIdx   = selCode[IDX_W-1:0];
          nextState = ST_LOCK;
        end else if (selCode == HOLD_CODE) begin
          nextState = ST_HOLD;
        end else begin
          nextState = ST_FREE;
        end
      end
      SRC_PEER: begin
        nextIdx   = peerIdx;
        nextState = peerState;
      end
      default: nextState = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      electedIdx <= '0;
      selIdx     <= '0;
      selState   <= ST_FREE;
    end else begin
      electedIdx <= autoNext;
      selIdx     <= nextIdx;
      selState   <= nextState;
    end
  end

  assign autoIdx = electedIdx;
endmodule

// File: rtl/refSelCtrl.sv
module refSelCtrl
  import refSelPkg::*;
#(
  parameter bit IS_LEADER = 1'b1,
  parameter int N_REFS    = 8,
  parameter int CODE_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          mode,
  input  logic                revertive,
  input  logic                holdoverOk,
  input  logic [CODE_W-1:0]   manualCode,
  input  logic [2*CODE_W-1:0] presetCodes,
  input  logic                pinLevel,
  input  pathFlag_t           flags,
  output ctrlStrobe_t         strobe,
  output logic [CODE_W-1:0]   selCode
);
  localparam logic [CODE_W-1:0] PEER_CODE = CODE_W'(N_REFS + 2);

  selState_e electState;
  selState_e electNext;
  logic      loadBest;
  outSrc_e   outSrc;

  // election state machine: lock / holdover / freerun
  always_comb begin
    loadBest  = 1'b0;
    electNext = electState;
    if (!flags.anyEligible) begin
      electNext = holdoverOk ? ST_HOLD : ST_FREE;
    end else begin
      electNext = ST_LOCK;
      if (electState != ST_LOCK || !flags.curEligible ||
          (revertive && flags.bestBetter)) begin
        loadBest = 1'b1;
      end
    end
  end

  // source of the selected output
  always_comb begin
    outSrc  = SRC_AUTO;
    selCode = manualCode;
    if (mode == MODE_MANUAL) begin
      outSrc = (!IS_LEADER && manualCode == PEER_CODE) ? SRC_PEER : SRC_CODE;
    end else if (IS_LEADER && mode == MODE_PIN) begin
      outSrc  = SRC_CODE;
      selCode = pinLevel ? presetCodes[2*CODE_W-1:CODE_W] : presetCodes[CODE_W-1:0];
    end
  end

  assign strobe = '{loadBest: loadBest, nextState: electNext, outSrc: outSrc};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) electState <= ST_FREE;
    else       electState <= electNext;
  end
endmodule

// File: rtl/refSelector.sv
module refSelector
  import refSelPkg::*;
#(
  parameter  int N_REFS = 8,
  parameter  int PRIO_W = 4,
  localparam int IDX_W  = $clog2(N_REFS),
  localparam int CODE_W = $clog2(N_REFS + 3)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [N_REFS-1:0]        refQualified,
  input  logic [N_REFS*PRIO_W-1:0] refPrio,
  input  logic                     holdoverOk,
  input  logic                     pinSwitch,
  input  logic [1:0]               priMode,
  input  logic                     priRevertive,
  input  logic [CODE_W-1:0]        priManual,
  input  logic [2*CODE_W-1:0]      priPreset,
  input  logic [1:0]               secMode,
  input  logic                     secRevertive,
  input  logic [CODE_W-1:0]        secManual,
  output logic [IDX_W-1:0]         priSelIdx,
  output logic [1:0]               priSelState,
  output logic [IDX_W-1:0]         priAutoIdx,
  output logic [IDX_W-1:0]         secSelIdx,
  output logic [1:0]               secSelState,
  output logic [IDX_W-1:0]         secAutoIdx
);
  localparam int N_CH = 2;

  logic              pinSync;
  logic [1:0]        modeArr   [N_CH];
  logic              revArr    [N_CH];
  logic [CODE_W-1:0] manualArr [N_CH];
  logic [IDX_W-1:0]  selIdxArr [N_CH];
  selState_e         stateArr  [N_CH];
  logic [IDX_W-1:0]  autoArr   [N_CH];
  logic [IDX_W-1:0]  nextIdxArr[N_CH];
  selState_e         nextStArr [N_CH];
  logic [IDX_W-1:0]  peerIdxArr[N_CH];
  selState_e         peerStArr [N_CH];

  assign modeArr[0]   = priMode;
  assign modeArr[1]   = secMode;
  assign revArr[0]    = priRevertive;
  assign revArr[1]    = secRevertive;
  assign manualArr[0] = priManual;
  assign manualArr[1] = secManual;

  refPinSync #(.STAGES(2)) uPinSync (
    .clk(clk), .rstN(rstN), .din(pinSwitch), .dout(pinSync)
  );

  for (genvar g = 0; g < N_CH; g++) begin : gCh
    ctrlStrobe_t       strobe;
    pathFlag_t         flags;
    logic [CODE_W-1:0] selCode;

    if (g == 0) begin : gLeadPeer
      assign peerIdxArr[g] = '0;
      assign peerStArr[g]  = ST_FREE;
    end else begin : gFollowPeer
      assign peerIdxArr[g] = nextIdxArr[0];
      assign peerStArr[g]  = nextStArr[0];
    end

    refSelCtrl #(
      .IS_LEADER(g == 0), .N_REFS(N_REFS), .CODE_W(CODE_W)
    ) uCtrl (
      .clk(clk), .rstN(rstN), .mode(modeArr[g]), .revertive(revArr[g]),
      .holdoverOk(holdoverOk), .manualCode(manualArr[g]),
      .presetCodes(priPreset), .pinLevel(pinSync), .flags(flags),
      .strobe(strobe), .selCode(selCode)
    );

    refSelPath #(
      .N_REFS(N_REFS), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .CODE_W(CODE_W)
    ) uPath (
      .clk(clk), .rstN(rstN), .refQualified(refQualified), .refPrio(refPrio),
      .strobe(strobe), .selCode(selCode),
      .peerIdx(peerIdxArr[g]), .peerState(peerStArr[g]),
      .flags(flags), .selIdx(selIdxArr[g]), .selState(stateArr[g]),
      .autoIdx(autoArr[g]), .nextIdx(nextIdxArr[g]), .nextState(nextStArr[g])
    );
  end

  assign priSelIdx   = selIdxArr[0];
  assign priSelState = stateArr[0];
  assign priAutoIdx  = autoArr[0];
  assign secSelIdx   = selIdxArr[1];
  assign secSelState = stateArr[1];
  assign secAutoIdx  = autoArr[1];
endmodule

// File: rtl/refSelChk.sv
module refSelChk #(
  parameter  int N_REFS = 8,
  parameter  int PRIO_W = 4,
  localparam int IDX_W  = $clog2(N_REFS),
  localparam int CODE_W = $clog2(N_REFS + 3)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [N_REFS-1:0]        refQualified,
  input logic [N_REFS*PRIO_W-1:0] refPrio,
  input logic                     holdoverOk,
  input logic [1:0]               priMode,
  input logic                     priRevertive,
  input logic [CODE_W-1:0]        priManual,
  input logic [1:0]               secMode,
  input logic [CODE_W-1:0]        secManual,
  input logic [IDX_W-1:0]         priSelIdx,
  input logic [1:0]               priSelState,
  input logic [IDX_W-1:0]         priAutoIdx,
  input logic [1:0]               secSelState
);
  logic [N_REFS-1:0] eligVec;

  always_comb begin
    for (int i = 0; i < N_REFS; i++) begin
      eligVec[i] = refQualified[i] && (refPrio[i*PRIO_W +: PRIO_W] != '0);
    end
  end

  p_state_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (priSelState != 2'b11) && (secSelState != 2'b11));

  p_holdover_r5: assert property (@(posedge clk) disable iff (!rstN)
    (priMode == 2'b00 && eligVec == '0 && holdoverOk) |=> (priSelState == 2'b01));

  p_freerun_r5: assert property (@(posedge clk) disable iff (!rstN)
    (priMode == 2'b00 && eligVec == '0 && !holdoverOk) |=> (priSelState == 2'b10));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (priMode == 2'b00 && eligVec != '0) |=> (priSelState == 2'b00));

  p_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(priMode) == 2'b00 && priSelState == 2'b00 && !priRevertive &&
     eligVec[priAutoIdx]) |=> $stable(priAutoIdx));

  p_manual_r8: assert property (@(posedge clk) disable iff (!rstN)
    (priMode == 2'b01 && priManual < CODE_W'(N_REFS)) |=>
    (priSelState == 2'b00 && priSelIdx == $past(priManual[IDX_W-1:0])));

  p_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (secMode == 2'b01 && secManual == CODE_W'(N_REFS + 2)) |=>
    (secSelState == priSelState));
endmodule

bind refSelector refSelChk #(.N_REFS(N_REFS), .PRIO_W(PRIO_W)) uChk (
  .clk(clk), .rstN(rstN), .refQualified(refQualified), .refPrio(refPrio),
  .holdoverOk(holdoverOk), .priMode(priMode), .priRevertive(priRevertive),
  .priManual(priManual), .secMode(secMode), .secManual(secManual),
  .priSelIdx(priSelIdx), .priSelState(priSelState), .priAutoIdx(priAutoIdx),
  .secSelState(secSelState)
);

// File: tb/refSelector_test.sv
module refSelector_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  refQualified = '0;
  logic [31:0] refPrio = '0;
  logic        holdoverOk = 1'b0;
  logic        pinSwitch = 1'b0;
  logic [1:0]  priMode = 2'b00;
  logic        rev = 1'b1;
  logic [3:0]  priManual = '0;
  logic [7:0]  priPreset = '0;
  logic [1:0]  secMode = 2'b01;
  logic [3:0]  secManual = 4'd10;
  logic [2:0]  priSelIdx, priAutoIdx, secSelIdx, secAutoIdx;
  logic [1:0]  priSelState, secSelState;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // election model from the requirements
  logic [1:0]  mSt = 2'b10;
  logic [2:0]  mIdx = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  refSelector uut (
    .clk(clk), .rstN(rstN), .refQualified(refQualified), .refPrio(refPrio),
    .holdoverOk(holdoverOk), .pinSwitch(pinSwitch), .priMode(priMode),
    .priRevertive(rev), .priManual(priManual), .priPreset(priPreset),
    .secMode(secMode), .secRevertive(rev), .secManual(secManual),
    .priSelIdx(priSelIdx), .priSelState(priSelState), .priAutoIdx(priAutoIdx),
    .secSelIdx(secSelIdx), .secSelState(secSelState), .secAutoIdx(secAutoIdx)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] prioOf(input int i);
    return refPrio[i*4 +: 4];
  endfunction

  function automatic bit eligOf(input int i);
    return refQualified[i] && (prioOf(i) != 0);
  endfunction

  task automatic modelStep();
    int  best = -1;
    for (int i = 0; i < 8; i++)
      if (eligOf(i) && (best < 0 || prioOf(i) < prioOf(best))) best = i;
    if (best < 0) mSt = holdoverOk ? 2'b01 : 2'b10;
    else if (mSt != 2'b00) begin mSt = 2'b00; mIdx = 3'(best); end
    else if (!eligOf(int'(mIdx))) mIdx = 3'(best);
    else if (rev && prioOf(best) < prioOf(int'(mIdx))) mIdx = 3'(best);
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tag;
    int    expIdx;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 priSelIdx", priSelIdx, 0);
    check("R1 priSelState", priSelState, 2);
    check("R1 priAutoIdx", priAutoIdx, 0);
    check("R1 secSelIdx", secSelIdx, 0);
    check("R1 secSelState", secSelState, 2);
    check("R1 secAutoIdx", secAutoIdx, 0);
    rstN = 1'b1;

    // sweep: automatic election, revertive then non-revertive
    for (int r = 0; r < 2; r++) begin
      rev = (r == 0);
      for (int s = 0; s < 512; s++) begin
        bit anyE;
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h0400_0007 : 32'h0);
        if (s % 8 == 0)
          for (int i = 0; i < 8; i++)
            refPrio[i*4 +: 4] = 4'((s * 7 + i * 5 + (s >> 3) + r) % 16);
        refQualified = (lfsr[3:0] == 0) ? 8'h00 : (lfsr[11:4] & lfsr[19:12]);
        holdoverOk = lfsr[21];
        anyE = 0;
        for (int i = 0; i < 8; i++) anyE |= eligOf(i);
        if (!anyE) tag = "R5";
        else if (mSt != 2'b00) tag = "R6";
        else if (rev) tag = "R3";
        else tag = "R4";
        tick();
        check({tag, " priSelState"}, priSelState, mSt);
        check({tag, " priSelIdx"}, priSelIdx, mIdx);
        check("R7 priAutoIdx", priAutoIdx, mIdx);
        check("R7 secAutoIdx", secAutoIdx, mIdx);
        check("R10 secSelIdx", secSelIdx, mIdx);
        check("R10 secSelState", secSelState, mSt);
      end
    end

    // R2 tie and zero-priority exclusion
    rev = 1'b1;
    refQualified = 8'h00;
    holdoverOk = 1'b0;
    tick();
    check("R5 freerun", priSelState, 2);
    refQualified = 8'hFF;
    refPrio = 32'h0030_0300;   // ref5=3, ref2=3, others 0
    tick();
    check("R2 tie lowest index", priSelIdx, 2);
    check("R6 relock state", priSelState, 0);
    refQualified = 8'hFB;      // drop ref2
    tick();
    check("R2 next candidate", priSelIdx, 5);

    // R8 manual sweep on the leader; R7 election keeps running
    priMode = 2'b01;
    refPrio = 32'h5555_5525;   // ref1 best
    refQualified = 8'hFF;
    expIdx = priSelIdx;
    for (int c = 0; c < 16; c++) begin
      int expSt;
      priManual = 4'(c);
      if (c < 8) begin expIdx = c; expSt = 0; end
      else if (c == 8) expSt = 1;
      else expSt = 2;
      tick();
      check("R8 manual state", priSelState, expSt);
      check("R8 manual idx", priSelIdx, expIdx);
      check("R7 auto under manual", priAutoIdx, mIdx);
    end
    check("R7 elected ref1", priAutoIdx, 1);

    // R9 pin mode
    priMode = 2'b10;
    priPreset = 8'h83;         // low: ref3, high: holdover
    tick();
    check("R9 pin low", priSelIdx, 3);
    check("R9 pin low state", priSelState, 0);
    pinSwitch = 1'b1;
    tick();
    check("R9 sync edge1", priSelState, 0);
    tick();
    check("R9 sync edge2", priSelState, 0);
    tick();
    check("R9 sync edge3", priSelState, 1);
    check("R9 holdover idx", priSelIdx, 3);
    priPreset = 8'h53;
    tick();
    check("R9 preset high ref", priSelIdx, 5);
    priPreset = 8'h93;
    tick();
    check("R9 preset freerun", priSelState, 2);
    pinSwitch = 1'b0;
    tick(); tick(); tick();
    check("R9 back low", priSelIdx, 3);
    check("R9 back low state", priSelState, 0);

    // R9 unused mode codes act as auto; R10 leader code 10 is freerun
    priMode = 2'b11;
    secMode = 2'b10;
    refPrio = 32'h5551_5555;   // ref4 best
    tick();
    check("R9 leader mode 11 auto", priSelIdx, 4);
    check("R9 follower mode 10 auto", secSelIdx, 4);
    check("R9 follower mode 10 state", secSelState, 0);
    priMode = 2'b01;
    priManual = 4'd10;
    secMode = 2'b01;
    tick();
    check("R10 leader code 10", priSelState, 2);
    check("R10 follower tracks", secSelState, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule